// File: doc/BRIEF.md
# Predicated Vector Element Issue Sequencer

The sequencer accepts one register-based vector operation at a time and breaks it into scalar element operations for an ALU that takes up to `LANES` elements per cycle. An operation carries a vector length, a predicate mask, a base register number for the destination and for two sources, and one flag per operand. The flag marks the operand as a vector, which steps through consecutive registers, or as a scalar, which keeps a single register.

Enabled elements are packed toward lane 0, so masked-out elements never occupy an ALU slot. An 8-element operation with 6 enabled elements takes 6 beats on a 1-lane ALU and 2 beats (4 then 2) on a 4-lane ALU. A per-operation zeroing mode turns this around: every element below the vector length is issued, and each masked-out element is tagged as a write of zero. When all three operands are scalar, the block issues one ordinary scalar operation.

The output uses a valid/ready handshake, so the ALU can hold the sequencer for any number of cycles. A done flag marks the final beat of each operation.

Top module: `elem_issue_seq`

## Requirements
- R1: After reset `out_valid` is 0 and `op_ready` is 1.
- R2: Without zeroing, an element index i is issued only if i < VL and mask bit i is 1. Each such element is issued exactly once, in ascending index order across lanes and beats.
- R3: Each beat fills lanes from lane 0 upward with no gaps. It holds min(LANES, remaining elements) lanes, so an operation with k elements takes ceil(k/LANES) beats.
- R4: The register number of an operand marked vector is (base + element index) mod 2^REG_W. An operand marked scalar always gives its base register.
- R5: When all three operand flags are 0 (scalar), exactly one beat is issued. In that beat lane 0 has index 0, all three base registers, `out_scalar` = 1, `out_done` = 1 and zero flag 0, whatever VL, mask and zeroing mode are.
- R6: With zeroing on (`op_zero` = 1), every index below VL is issued. A lane's `out_zero` bit is 1 exactly when its mask bit is 0.
- R7: `out_done` is 1 only on the last beat of an operation. An operation with no element to issue (VL = 0, or no mask bit below VL without zeroing) produces a single beat with no valid lane and `out_done` = 1.
- R8: While `out_valid` = 1 and `out_ready` = 0, every output stays unchanged on the next cycle. No element is lost or repeated.
- R9: `op_ready` is 0 from the cycle after an operation is accepted until the beat with `out_done` has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Sequencer idle, operation taken when op_valid is 1 |
| op_vl | input | VL_W | Vector length |
| op_mask | input | XLEN | Predicate, bit i enables element i |
| op_rd_vec | input | 1 | Destination is a vector |
| op_rs1_vec | input | 1 | Source 1 is a vector |
| op_rs2_vec | input | 1 | Source 2 is a vector |
| op_zero | input | 1 | Zeroing mode for masked elements |
| op_rd | input | REG_W | Destination base register |
| op_rs1 | input | REG_W | Source 1 base register |
| op_rs2 | input | REG_W | Source 2 base register |
| out_valid | output | 1 | A beat is presented |
| out_ready | input | 1 | ALU takes the beat |
| out_lane_vld | output | LANES | Per-lane valid |
| out_idx | output | LANES*IDX_W | Per-lane element index |
| out_rd | output | LANES*REG_W | Per-lane destination register |
| out_rs1 | output | LANES*REG_W | Per-lane source 1 register |
| out_rs2 | output | LANES*REG_W | Per-lane source 2 register |
| out_zero | output | LANES | Per-lane write-zero flag |
| out_scalar | output | 1 | Beat is a plain scalar operation |
| out_done | output | 1 | Last beat of the operation |

## Verification
The hardest condition to reach is a stall on a partly consumed operation: a beat must be held while some of the mask is already retired and the rest has not been issued. The bench gets there by driving `out_ready` from a pseudo-random pattern that is low about a third of the time. Because many random operations carry dense masks with lengths above the lane count, stalls fall on first, middle and final beats alike. Register wrap-around is reached by placing vector bases near the top of the register space. The empty-operation beat is reached with VL = 0 and with masks whose set bits all lie at or above VL.

// File: rtl/seq_pkg.sv
package seq_pkg;

   // Position of the set bit in a one-hot (or zero) vector.
   function automatic logic [5:0] oh2idx(input logic [63:0] oh);
      logic [5:0] r;
      r = '0;
      for (int i = 0; i < 64; i++)
         if (oh[i]) r = r | 6'(i);
      return r;
   endfunction

endpackage

// File: rtl/seq_pick.sv
module seq_pick
   import seq_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int LANES = 4,
   localparam int IDX_W = $clog2(XLEN)
) (
   input  logic [XLEN-1:0]        pend,
   output logic [XLEN-1:0]        take,
   output logic [LANES-1:0]       lane_vld,
   output logic [LANES*IDX_W-1:0] lane_idx
);

   logic [XLEN-1:0] rem [LANES+1];
   assign rem[0] = pend;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [XLEN-1:0] low;
      logic [63:0]     low_ext;
      assign low         = rem[k] & ~(rem[k] - XLEN'(1));
      assign rem[k+1]    = rem[k] & (rem[k] - XLEN'(1));
      assign lane_vld[k] = |rem[k];
      assign low_ext     = 64'(low);
      assign lane_idx[k*IDX_W +: IDX_W] = IDX_W'(oh2idx(low_ext));
   end

   assign take = rem[0] & ~rem[LANES];

endmodule

// File: rtl/seq_regmap.sv
module seq_regmap #(
   parameter int XLEN  = 32,
   parameter int LANES = 4,
   parameter int REG_W = 5,
   localparam int IDX_W = $clog2(XLEN)
) (
   input  logic [LANES*IDX_W-1:0] lane_idx,
   input  logic [LANES-1:0]       lane_vld,
   input  logic [XLEN-1:0]        mask,
   input  logic                   zero_mode,
   input  logic                   rd_vec,
   input  logic                   rs1_vec,
   input  logic                   rs2_vec,
   input  logic [REG_W-1:0]       rd_base,
   input  logic [REG_W-1:0]       rs1_base,
   input  logic [REG_W-1:0]       rs2_base,
   output logic [LANES*REG_W-1:0] rd_o,
   output logic [LANES*REG_W-1:0] rs1_o,
   output logic [LANES*REG_W-1:0] rs2_o,
   output logic [LANES-1:0]       zero_o
);

   for (genvar k = 0; k < LANES; k++) begin : g_map
      logic [IDX_W-1:0] idx;
      logic [REG_W-1:0] off;
      assign idx = lane_idx[k*IDX_W +: IDX_W];
      assign off = REG_W'(idx);
      assign rd_o [k*REG_W +: REG_W] = rd_vec  ? REG_W'(rd_base  + off) : rd_base;
      assign rs1_o[k*REG_W +: REG_W] = rs1_vec ? REG_W'(rs1_base + off) : rs1_base;
      assign rs2_o[k*REG_W +: REG_W] = rs2_vec ? REG_W'(rs2_base + off) : rs2_base;
      assign zero_o[k] = lane_vld[k] & zero_mode & ~mask[idx];
   end

endmodule

// File: rtl/elem_issue_seq.sv
module elem_issue_seq #(
   parameter int XLEN  = 32,
   parameter int LANES = 4,
   parameter int REG_W = 5,
   localparam int IDX_W = $clog2(XLEN),
   localparam int VL_W  = $clog2(XLEN + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   op_valid,
   output logic                   op_ready,
   input  logic [VL_W-1:0]        op_vl,
   input  logic [XLEN-1:0]        op_mask,
   input  logic                   op_rd_vec,
   input  logic                   op_rs1_vec,
   input  logic                   op_rs2_vec,
   input  logic                   op_zero,
   input  logic [REG_W-1:0]       op_rd,
   input  logic [REG_W-1:0]       op_rs1,
   input  logic [REG_W-1:0]       op_rs2,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic [LANES-1:0]       out_lane_vld,
   output logic [LANES*IDX_W-1:0] out_idx,
   output logic [LANES*REG_W-1:0] out_rd,
   output logic [LANES*REG_W-1:0] out_rs1,
   output logic [LANES*REG_W-1:0] out_rs2,
   output logic [LANES-1:0]       out_zero,
   output logic                   out_scalar,
   output logic                   out_done
);

   // elaboration-time parameter checks
   if (!(LANES == 1 || LANES == 2 || LANES == 4 || LANES == 8)) begin : g_bad_lanes
      $error("LANES must be 1, 2, 4 or 8");
   end
   if (XLEN < 2 || XLEN > 64) begin : g_bad_xlen
      $error("XLEN must lie in 2..64");
   end
   if (REG_W < 1) begin : g_bad_regw
      $error("REG_W must be positive");
   end

   logic             busy_q, scal_q, zero_q;
   logic             rdv_q, rs1v_q, rs2v_q;
   logic [REG_W-1:0] rd_q, rs1_q, rs2_q;
   logic [XLEN-1:0]  mask_q, pend_q;
   logic [VL_W-1:0]  vl_q;

   logic [XLEN-1:0]  below_vl, pend_init, take;
   logic             all_scalar, op_fire, out_fire;

   always_comb begin
      for (int i = 0; i < XLEN; i++)
         below_vl[i] = (VL_W'(i) < op_vl);
   end

   assign all_scalar = ~(op_rd_vec | op_rs1_vec | op_rs2_vec);
   assign pend_init  = all_scalar ? XLEN'(1) :
                       op_zero    ? below_vl : (below_vl & op_mask);
   assign op_ready   = ~busy_q;
   assign op_fire    = op_valid & ~busy_q;
   assign out_valid  = busy_q;
   assign out_fire   = busy_q & out_ready;
   assign out_done   = busy_q & ((pend_q & ~take) == '0);
   assign out_scalar = busy_q & scal_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         scal_q <= 1'b0;
         zero_q <= 1'b0;
         rdv_q  <= 1'b0;
         rs1v_q <= 1'b0;
         rs2v_q <= 1'b0;
         rd_q   <= '0;
         rs1_q  <= '0;
         rs2_q  <= '0;
         mask_q <= '0;
         pend_q <= '0;
         vl_q   <= '0;
      end else if (op_fire) begin
         busy_q <= 1'b1;
         scal_q <= all_scalar;
         zero_q <= op_zero & ~all_scalar;
         rdv_q  <= op_rd_vec;
         rs1v_q <= op_rs1_vec;
         rs2v_q <= op_rs2_vec;
         rd_q   <= op_rd;
         rs1_q  <= op_rs1;
         rs2_q  <= op_rs2;
         mask_q <= op_mask;
         pend_q <= pend_init;
         vl_q   <= op_vl;
      end else if (out_fire) begin
         pend_q <= pend_q & ~take;
         if (out_done) busy_q <= 1'b0;
      end
   end

   logic [LANES-1:0] lane_vld;

   seq_pick #(.XLEN(XLEN), .LANES(LANES)) u_pick (
      .pend     (pend_q),
      .take     (take),
      .lane_vld (lane_vld),
      .lane_idx (out_idx)
   );

   assign out_lane_vld = lane_vld & {LANES{busy_q}};

   seq_regmap #(.XLEN(XLEN), .LANES(LANES), .REG_W(REG_W)) u_map (
      .lane_idx  (out_idx),
      .lane_vld  (out_lane_vld),
      .mask      (mask_q),
      .zero_mode (zero_q),
      .rd_vec    (rdv_q),
      .rs1_vec   (rs1v_q),
      .rs2_vec   (rs2v_q),
      .rd_base   (rd_q),
      .rs1_base  (rs1_q),
      .rs2_base  (rs2_q),
      .rd_o      (out_rd),
      .rs1_o     (out_rs1),
      .rs2_o     (out_rs2),
      .zero_o    (out_zero)
   );

   // ---------------- assertions ----------------
   assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_lane_vld) &&
       $stable(out_idx) && $stable(out_rd) && $stable(out_zero) && $stable(out_done)));

   assert_lane_pack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_lane_vld & (out_lane_vld + LANES'(1))) == '0));

   assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !op_ready);

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_done) |=> op_ready);

   assert_scalar_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_scalar) |-> (out_done && out_lane_vld == LANES'(1) && out_zero == '0));

   assert_zero_needs_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((out_zero & ~out_lane_vld) == '0));

   for (genvar k = 0; k < LANES; k++) begin : g_chk
      assert_idx_below_vl_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (out_lane_vld[k] && !out_scalar) |-> (VL_W'(out_idx[k*IDX_W +: IDX_W]) < vl_q));
      if (k > 0) begin : g_ord
         assert_idx_rising_R2: assert property (@(posedge clk) disable iff (!rst_n)
            out_lane_vld[k] |-> (out_idx[k*IDX_W +: IDX_W] > out_idx[(k-1)*IDX_W +: IDX_W]));
      end
   end

endmodule

// File: tb/sim_elem_issue_seq.sv
module sim_elem_issue_seq;

   localparam int XLEN  = 32;
   localparam int LANES = 4;
   localparam int REG_W = 5;
   localparam int IDX_W = $clog2(XLEN);
   localparam int VL_W  = $clog2(XLEN + 1);

   typedef struct packed {
      logic [IDX_W-1:0] idx;
      logic [REG_W-1:0] rd;
      logic [REG_W-1:0] rs1;
      logic [REG_W-1:0] rs2;
      logic             z;
      logic             s;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic op_valid = 1'b0;
   logic op_ready;
   logic [VL_W-1:0] op_vl = '0;
   logic [XLEN-1:0] op_mask = '0;
   logic op_rd_vec = 1'b0, op_rs1_vec = 1'b0, op_rs2_vec = 1'b0, op_zero = 1'b0;
   logic [REG_W-1:0] op_rd = '0, op_rs1 = '0, op_rs2 = '0;
   logic out_valid;
   logic out_ready = 1'b0;
   logic [LANES-1:0] out_lane_vld, out_zero;
   logic [LANES*IDX_W-1:0] out_idx;
   logic [LANES*REG_W-1:0] out_rd, out_rs1, out_rs2;
   logic out_scalar, out_done;

   always #2 clk = ~clk;   // 250 MHz

   elem_issue_seq #(.XLEN(XLEN), .LANES(LANES), .REG_W(REG_W)) u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
      .op_vl(op_vl), .op_mask(op_mask), .op_rd_vec(op_rd_vec),
      .op_rs1_vec(op_rs1_vec), .op_rs2_vec(op_rs2_vec), .op_zero(op_zero),
      .op_rd(op_rd), .op_rs1(op_rs1), .op_rs2(op_rs2),
      .out_valid(out_valid), .out_ready(out_ready), .out_lane_vld(out_lane_vld),
      .out_idx(out_idx), .out_rd(out_rd), .out_rs1(out_rs1), .out_rs2(out_rs2),
      .out_zero(out_zero), .out_scalar(out_scalar), .out_done(out_done)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic check(input logic ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   item_t item_q[$];
   int    cnt_q[$];
   int    stall_pct = 0;

   // Driver: compute expected elements, then present the operation.
   task automatic send_op(input int vl, input logic [XLEN-1:0] mask, input logic rdv,
                          input logic s1v, input logic s2v, input logic zm,
                          input logic [REG_W-1:0] rd, input logic [REG_W-1:0] rs1,
                          input logic [REG_W-1:0] rs2);
      int n = 0;
      item_t it;
      if (!(rdv || s1v || s2v)) begin
         it = '{idx: '0, rd: rd, rs1: rs1, rs2: rs2, z: 1'b0, s: 1'b1};
         item_q.push_back(it);
         n = 1;
      end else begin
         for (int i = 0; i < XLEN; i++) begin
            if (i < vl && (zm || mask[i])) begin
               it.idx = IDX_W'(i);
               it.rd  = rdv ? REG_W'(rd  + REG_W'(i)) : rd;
               it.rs1 = s1v ? REG_W'(rs1 + REG_W'(i)) : rs1;
               it.rs2 = s2v ? REG_W'(rs2 + REG_W'(i)) : rs2;
               it.z   = zm && !mask[i];
               it.s   = 1'b0;
               item_q.push_back(it);
               n++;
            end
         end
      end
      cnt_q.push_back(n);
      @(negedge clk);
      while (!op_ready) @(negedge clk);
      op_valid = 1'b1; op_vl = VL_W'(vl); op_mask = mask;
      op_rd_vec = rdv; op_rs1_vec = s1v; op_rs2_vec = s2v; op_zero = zm;
      op_rd = rd; op_rs1 = rs1; op_rs2 = rs2;
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   // Monitor: drives ready, compares each taken beat, checks stall hold.
   bit in_op = 0;
   int cur_rem = 0;
   logic stalled_prev = 1'b0;
   logic [LANES-1:0] sv_vld;
   logic [LANES*IDX_W-1:0] sv_idx;
   logic [LANES*REG_W-1:0] sv_rd;
   logic sv_done;

   always @(negedge clk) begin
      if (rst_n) begin
         logic rdy;
         rdy = ($urandom_range(99) >= stall_pct);
         out_ready = rdy;
         if (stalled_prev) begin
            check(out_valid && out_lane_vld == sv_vld && out_idx == sv_idx &&
                  out_rd == sv_rd && out_done == sv_done, "R8 stall hold",
                  64'(out_idx), 64'(sv_idx));
         end
         stalled_prev = out_valid && !rdy;
         sv_vld = out_lane_vld; sv_idx = out_idx; sv_rd = out_rd; sv_done = out_done;
         if (out_valid && rdy) begin
            int nl;
            if (!in_op) begin
               cur_rem = (cnt_q.size() > 0) ? cnt_q.pop_front() : 0;
               in_op = 1;
            end
            nl = (cur_rem < LANES) ? cur_rem : LANES;
            // R3: lanes packed from lane 0, min(LANES, remaining)
            check(out_lane_vld == LANES'((1 << nl) - 1), "R3 lane count",
                  64'(out_lane_vld), 64'((1 << nl) - 1));
            for (int k = 0; k < LANES; k++) begin
               if (k < nl && item_q.size() > 0) begin
                  item_t e, a;
                  e = item_q.pop_front();
                  a.idx = out_idx[k*IDX_W +: IDX_W];
                  a.rd  = out_rd [k*REG_W +: REG_W];
                  a.rs1 = out_rs1[k*REG_W +: REG_W];
                  a.rs2 = out_rs2[k*REG_W +: REG_W];
                  a.z   = out_zero[k];
                  a.s   = out_scalar;
                  // R2 order/enable, R4 registers, R5 scalar, R6 zero flag
                  check(a == e, "R2/R4/R5/R6 lane item", 64'(a), 64'(e));
               end
            end
            cur_rem -= nl;
            check(out_done == (cur_rem == 0), "R7 done flag", 64'(out_done),
                  64'(cur_rem == 0));
            if (out_done) in_op = 0;
         end
      end
   end

   task automatic drain();
      int guard = 0;
      while ((cnt_q.size() > 0 || in_op || !op_ready || item_q.size() > 0) && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
   endtask

   bit finished = 0;

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check(out_valid == 1'b0, "R1 out_valid in reset", 64'(out_valid), 64'(0));
      check(op_ready == 1'b1, "R1 op_ready in reset", 64'(op_ready), 64'(1));
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'(0));

      // R3: 8 elements, 6 enabled -> 4 then 2
      send_op(8, 32'h0000_00BB, 1, 1, 1, 0, 5'd2, 5'd10, 5'd20);
      // R9: busy while the operation is in flight
      #1 check(op_ready == 1'b0, "R9 op_ready while busy", 64'(op_ready), 64'(0));
      drain();
      // R5: all scalar, mask and VL ignored
      send_op(0, 32'h0, 0, 0, 0, 1, 5'd7, 5'd8, 5'd9);
      drain();
      // R4: scalar-vector mix with wrap of the destination
      send_op(6, 32'h0000_003F, 1, 0, 1, 0, 5'd29, 5'd3, 5'd30);
      drain();
      // R6: zeroing mode
      send_op(10, 32'h0000_0155, 1, 1, 0, 1, 5'd4, 5'd12, 5'd1);
      drain();
      // R7: empty operations
      send_op(5, 32'hFFFF_FFE0, 1, 1, 1, 0, 5'd0, 5'd0, 5'd0);
      send_op(0, 32'hFFFF_FFFF, 0, 1, 0, 0, 5'd1, 5'd2, 5'd3);
      drain();
      // full length, full mask
      send_op(XLEN, 32'hFFFF_FFFF, 1, 1, 1, 0, 5'd0, 5'd16, 5'd31);
      drain();
      // R8: random operations under random back-pressure
      stall_pct = 35;
      for (int t = 0; t < 150; t++) begin
         send_op($urandom_range(XLEN), $urandom, 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom_range(3) == 0), 5'($urandom),
                 5'($urandom), 5'($urandom));
      end
      drain();
      stall_pct = 0;
      check(item_q.size() == 0 && cnt_q.size() == 0, "R2 all elements issued",
            64'(item_q.size()), 64'(0));
      finished = 1;
   end

   initial begin
      int cyc = 0;
      while (!finished && cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule